// File: doc/BRIEF.md
# Power-on self-test sequencer

This block runs a fixed chain of built-in checks each time the chip leaves reset. The first check is a lamp test. An all-ones pattern is shifted out on a serial display data line, and the pattern is sent twice back to back. After that the display stays lit for a programmable hold time, which is about three seconds in silicon.

Next the block reads every byte of a ROM through a synchronous read port. It adds all bytes except the last two, and compares that sum with the 16-bit value held in those two bytes. It then starts an external RAM tester, and after that an external channel loopback tester. Each tester uses a start pulse and a done/pass reply. The first failing step ends the chain at once.

A registered result code with a valid flag reports the outcome: good, controller fault or channel fault. The code stays put until a new run begins. A new run begins only if the test-mode input is high when a run finishes, so the chain repeats for as long as that input stays high.

Top module: `post_sequencer`

## Requirements
- R1: While reset is held and after it is released, `result_valid_o` is 0 and `result_code_o` is 0 until the first run ends; exactly one run starts after reset without any input.
- R2: The lamp test gives exactly 2*PATTERN_BITS cycles with `disp_shift_o` high, and `disp_data_o` is 1 in every one of them.
- R3: The first ROM read comes no sooner than LAMP_HOLD cycles and no later than LAMP_HOLD+6 cycles after the last lamp strobe.
- R4: The ROM check issues exactly 2^ROM_AW reads, one per cycle, at addresses 0, 1, 2 … in ascending order. Read data is taken in the cycle after `rom_rd_o`.
- R5: The ROM passes when (sum of bytes 0..N-3, modulo 65536) equals byte[N-1]*256 + byte[N-2], where N = 2^ROM_AW. On a mismatch the run ends with code 2 (controller fault), and neither tester is started.
- R6: After a ROM pass, `ram_start_o` pulses high for exactly one cycle. If the RAM tester replies with pass=0, the run ends with code 2 and `chan_start_o` never pulses.
- R7: After a RAM pass, `chan_start_o` pulses for one cycle. If the channel tester fails, the code is 3 (channel fault). If it passes, the code is 1 (good). `result_valid_o` is never high with code 0.
- R8: While `result_valid_o` is high, `result_code_o` does not change. With test mode low, the result is held indefinitely and no test activity occurs.
- R9: If `test_mode_i` is high when a run has finished, a new run starts. `result_valid_o` drops and the code returns to 0. `result_valid_o` only falls after a cycle in which `test_mode_i` was high.
- R10: At most one of lamp strobe, ROM read, RAM start and channel start is active in any cycle, and none is active while `result_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode_i | input | 1 | Repeat request; sampled when a run has finished |
| disp_data_o | output | 1 | Serial display data bit |
| disp_shift_o | output | 1 | Strobe marking a valid display data bit |
| rom_rd_o | output | 1 | ROM read enable |
| rom_addr_o | output | ROM_AW | ROM byte address |
| rom_data_i | input | 8 | ROM data, valid the cycle after a read |
| ram_start_o | output | 1 | One-cycle start pulse to the RAM tester |
| ram_done_i | input | 1 | RAM tester finished (one-cycle pulse) |
| ram_pass_i | input | 1 | RAM tester result, sampled with done |
| chan_start_o | output | 1 | One-cycle start pulse to the channel loopback tester |
| chan_done_i | input | 1 | Channel tester finished (one-cycle pulse) |
| chan_pass_i | input | 1 | Channel tester result, sampled with done |
| result_code_o | output | 2 | 0 none, 1 good, 2 controller fault, 3 channel fault |
| result_valid_o | output | 1 | Result code is final and held |

## Verification
The bench builds the block with PATTERN_BITS=8, LAMP_HOLD=20 and ROM_AW=9. With these values the full lamp sequence and hold window can be counted exactly. The 512-byte ROM is large enough that an all-0xFF image overflows 16 bits, so the modulo-65536 wrap is checked and not just assumed. The bench sweeps several ROM images and compares each against a sum it computes itself:
- a correct image,
- an image off by one,
- an image with the two sum bytes swapped,
- an all-zero image,
- an all-0xFF image.

It also tries every tester reply combination, checking the skip rules, and it covers both the repeat path and the idle-hold path of the test-mode input.

// File: rtl/post_pkg.sv
package post_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_GOOD = 2'd1,
        RES_CTRL = 2'd2,
        RES_CHAN = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_LAMP,
        ST_HOLD,
        ST_ROM,
        ST_RAM,
        ST_CHAN,
        ST_DONE
    } seq_e;

    typedef struct packed {
        seq_e    st;
        result_e code;
        logic    valid;
        logic    lamp_go;
        logic    hold_go;
        logic    rom_go;
        logic    ram_go;
        logic    chan_go;
    } seq_t;

endpackage

// File: rtl/post_lamp_shifter.sv
module post_lamp_shifter #(
    parameter int BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic bit_o,
    output logic strobe_o,
    output logic done_o
);
    localparam int TOTAL = 2 * BITS;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          done;
    } lamp_t;

    lamp_t lamp_d, lamp_q;

    always_comb begin
        lamp_d      = lamp_q;
        lamp_d.done = 1'b0;
        if (go_i) begin
            lamp_d.active = 1'b1;
            lamp_d.cnt    = '0;
        end else if (lamp_q.active) begin
            lamp_d.cnt = lamp_q.cnt + 1'b1;
            if (lamp_q.cnt == LAST) begin
                lamp_d.active = 1'b0;
                lamp_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_q <= '0;
        end else begin
            lamp_q <= lamp_d;
        end
    end

    assign strobe_o = lamp_q.active;
    assign bit_o    = lamp_q.active;
    assign done_o   = lamp_q.done;

endmodule

// File: rtl/post_cycle_timer.sv
module post_cycle_timer #(
    parameter int CYCLES = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (go_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = LOAD;
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.active = 1'b0;
                tmr_d.done   = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = tmr_q.done;

endmodule

// File: rtl/post_rom_summer.sv
module post_rom_summer #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    output logic          rom_rd_o,
    output logic [AW-1:0] rom_addr_o,
    input  logic [7:0]    rom_data_i,
    output logic          done_o,
    output logic          match_o
);
    localparam int DEPTH = 1 << AW;
    localparam int IW    = AW + 1;
    localparam logic [IW-1:0] ISS_LAST = IW'(DEPTH - 1);
    localparam logic [AW-1:0] ADR_LO   = AW'(DEPTH - 2);
    localparam logic [AW-1:0] ADR_HI   = AW'(DEPTH - 1);

    typedef struct packed {
        logic          issuing;
        logic [IW-1:0] iss;
        logic          ret_v;
        logic [AW-1:0] ret_a;
        logic [15:0]   sum;
        logic [7:0]    lo;
        logic          done;
        logic          match;
    } sum_t;

    sum_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;

        // consume data returned for the read issued last cycle
        if (s_q.ret_v) begin
            if (s_q.ret_a == ADR_LO) begin
                s_d.lo = rom_data_i;
            end else if (s_q.ret_a == ADR_HI) begin
                s_d.done  = 1'b1;
                s_d.match = (s_q.sum == {rom_data_i, s_q.lo});
            end else begin
                s_d.sum = s_q.sum + {8'h00, rom_data_i};
            end
        end

        if (go_i) begin
            s_d.issuing = 1'b1;
            s_d.iss     = '0;
            s_d.sum     = '0;
            s_d.ret_v   = 1'b0;
            s_d.match   = 1'b0;
        end else begin
            s_d.ret_v = s_q.issuing;
            s_d.ret_a = s_q.iss[AW-1:0];
            if (s_q.issuing) begin
                s_d.iss = s_q.iss + 1'b1;
                if (s_q.iss == ISS_LAST) begin
                    s_d.issuing = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rom_rd_o   = s_q.issuing;
    assign rom_addr_o = s_q.iss[AW-1:0];
    assign done_o     = s_q.done;
    assign match_o    = s_q.match;

endmodule

// File: rtl/post_sequencer.sv
module post_sequencer
    import post_pkg::*;
#(
    parameter int PATTERN_BITS = 32,
    parameter int LAMP_HOLD    = 150_000_000,
    parameter int ROM_AW       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode_i,
    output logic              disp_data_o,
    output logic              disp_shift_o,
    output logic              rom_rd_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [7:0]        rom_data_i,
    output logic              ram_start_o,
    input  logic              ram_done_i,
    input  logic              ram_pass_i,
    output logic              chan_start_o,
    input  logic              chan_done_i,
    input  logic              chan_pass_i,
    output logic [1:0]        result_code_o,
    output logic              result_valid_o
);
    seq_t seq_d, seq_q;

    logic lamp_done;
    logic hold_done;
    logic rom_done;
    logic rom_match;

    post_lamp_shifter #(.BITS(PATTERN_BITS)) i_lamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (seq_q.lamp_go),
        .bit_o    (disp_data_o),
        .strobe_o (disp_shift_o),
        .done_o   (lamp_done)
    );

    post_cycle_timer #(.CYCLES(LAMP_HOLD)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (seq_q.hold_go),
        .done_o (hold_done)
    );

    post_rom_summer #(.AW(ROM_AW)) i_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (seq_q.rom_go),
        .rom_rd_o   (rom_rd_o),
        .rom_addr_o (rom_addr_o),
        .rom_data_i (rom_data_i),
        .done_o     (rom_done),
        .match_o    (rom_match)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.lamp_go = 1'b0;
        seq_d.hold_go = 1'b0;
        seq_d.rom_go  = 1'b0;
        seq_d.ram_go  = 1'b0;
        seq_d.chan_go = 1'b0;
        unique case (seq_q.st)
            ST_START: begin
                seq_d.valid   = 1'b0;
                seq_d.code    = RES_NONE;
                seq_d.lamp_go = 1'b1;
                seq_d.st      = ST_LAMP;
            end
            ST_LAMP: begin
                if (lamp_done) begin
                    seq_d.hold_go = 1'b1;
                    seq_d.st      = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (hold_done) begin
                    seq_d.rom_go = 1'b1;
                    seq_d.st     = ST_ROM;
                end
            end
            ST_ROM: begin
                if (rom_done) begin
                    if (rom_match) begin
                        seq_d.ram_go = 1'b1;
                        seq_d.st     = ST_RAM;
                    end else begin
                        seq_d.code  = RES_CTRL;
                        seq_d.valid = 1'b1;
                        seq_d.st    = ST_DONE;
                    end
                end
            end
            ST_RAM: begin
                if (ram_done_i) begin
                    if (ram_pass_i) begin
                        seq_d.chan_go = 1'b1;
                        seq_d.st      = ST_CHAN;
                    end else begin
                        seq_d.code  = RES_CTRL;
                        seq_d.valid = 1'b1;
                        seq_d.st    = ST_DONE;
                    end
                end
            end
            ST_CHAN: begin
                if (chan_done_i) begin
                    seq_d.code  = chan_pass_i ? RES_GOOD : RES_CHAN;
                    seq_d.valid = 1'b1;
                    seq_d.st    = ST_DONE;
                end
            end
            ST_DONE: begin
                if (test_mode_i) begin
                    seq_d.st = ST_START;
                end
            end
            default: begin
                seq_d.st = ST_START;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_START, code: RES_NONE, valid: 1'b0,
                       lamp_go: 1'b0, hold_go: 1'b0, rom_go: 1'b0,
                       ram_go: 1'b0, chan_go: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ram_start_o    = seq_q.ram_go;
    assign chan_start_o   = seq_q.chan_go;
    assign result_code_o  = seq_q.code;
    assign result_valid_o = seq_q.valid;

endmodule

// File: rtl/post_sequencer_chk.sv
module post_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_mode_i,
    input logic       disp_data_o,
    input logic       disp_shift_o,
    input logic       rom_rd_o,
    input logic       ram_start_o,
    input logic       chan_start_o,
    input logic [1:0] result_code_o,
    input logic       result_valid_o
);
    // R2
    lamp_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_shift_o |-> disp_data_o);

    // R6
    ram_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_start_o |=> !ram_start_o);

    // R7
    chan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start_o |=> !chan_start_o);

    // R7
    code_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> (result_code_o != 2'd0));

    // R8
    code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid_o && $past(result_valid_o)) |-> $stable(result_code_o));

    // R9
    restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(result_valid_o) |-> $past(test_mode_i));

    // R10
    one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({disp_shift_o, rom_rd_o, ram_start_o, chan_start_o}) <= 1);

    // R10
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> !(disp_shift_o || rom_rd_o || ram_start_o || chan_start_o));

endmodule

bind post_sequencer post_sequencer_chk i_post_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .test_mode_i    (test_mode_i),
    .disp_data_o    (disp_data_o),
    .disp_shift_o   (disp_shift_o),
    .rom_rd_o       (rom_rd_o),
    .ram_start_o    (ram_start_o),
    .chan_start_o   (chan_start_o),
    .result_code_o  (result_code_o),
    .result_valid_o (result_valid_o)
);

// File: tb/test_post_sequencer.sv
`timescale 1ns/1ps
module test_post_sequencer;
    localparam int PB   = 8;
    localparam int HOLD = 20;
    localparam int AW   = 9;
    localparam int N    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_mode_i = 1'b0;
    logic          disp_data_o, disp_shift_o;
    logic          rom_rd_o;
    logic [AW-1:0] rom_addr_o;
    logic [7:0]    rom_data_i;
    logic          ram_start_o, ram_done_i = 1'b0, ram_pass_i = 1'b0;
    logic          chan_start_o, chan_done_i = 1'b0, chan_pass_i = 1'b0;
    logic [1:0]    result_code_o;
    logic          result_valid_o;

    logic [7:0] rom [N];
    logic cfg_ram_pass = 1'b1;
    logic cfg_chan_pass = 1'b1;

    int n_checks = 0;
    int n_fail = 0;

    // activity monitor counters
    int cyc = 0, strobes = 0, zero_bits = 0, reads = 0, order_err = 0;
    int ram_starts = 0, chan_starts = 0, last_strobe = 0, gap = 0;
    logic prev_rd = 1'b0;

    always #10 clk = ~clk;

    post_sequencer #(.PATTERN_BITS(PB), .LAMP_HOLD(HOLD), .ROM_AW(AW)) i_post_sequencer (
        .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i),
        .disp_data_o(disp_data_o), .disp_shift_o(disp_shift_o),
        .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .ram_start_o(ram_start_o), .ram_done_i(ram_done_i), .ram_pass_i(ram_pass_i),
        .chan_start_o(chan_start_o), .chan_done_i(chan_done_i), .chan_pass_i(chan_pass_i),
        .result_code_o(result_code_o), .result_valid_o(result_valid_o)
    );

    always_ff @(posedge clk) begin
        if (rom_rd_o) rom_data_i <= rom[rom_addr_o];
    end

    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            if (disp_shift_o) begin
                strobes = strobes + 1;
                if (!disp_data_o) zero_bits = zero_bits + 1;
                last_strobe = cyc;
            end
            if (rom_rd_o) begin
                if (!prev_rd) begin
                    gap = cyc - last_strobe;
                    reads = 0;
                end
                if (rom_addr_o != AW'(reads)) order_err = order_err + 1;
                reads = reads + 1;
            end
            prev_rd = rom_rd_o;
            if (ram_start_o) ram_starts = ram_starts + 1;
            if (chan_start_o) chan_starts = chan_starts + 1;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (ram_start_o) begin
                repeat (3) @(negedge clk);
                ram_pass_i = cfg_ram_pass;
                ram_done_i = 1'b1;
                @(negedge clk);
                ram_done_i = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (chan_start_o) begin
                repeat (5) @(negedge clk);
                chan_pass_i = cfg_chan_pass;
                chan_done_i = 1'b1;
                @(negedge clk);
                chan_done_i = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] body_sum();
        logic [15:0] s = 16'h0;
        for (int i = 0; i < N - 2; i++) s = s + {8'h00, rom[i]};
        return s;
    endfunction

    // kinds: 0 good pattern, 1 off by one, 2 swapped sum bytes, 3 all 0xFF good, 4 all zero good
    task automatic fill_rom(input int kind);
        logic [15:0] s;
        for (int i = 0; i < N - 2; i++) begin
            if (kind == 3) rom[i] = 8'hFF;
            else if (kind == 4) rom[i] = 8'h00;
            else rom[i] = 8'((i * 37 + 5) & 255);
        end
        s = body_sum();
        if (kind == 2 && s[15:8] == s[7:0]) begin
            rom[0] = rom[0] + 8'd1;
            s = body_sum();
        end
        if (kind == 1) s = s + 16'd1;
        if (kind == 2) s = {s[7:0], s[15:8]};
        rom[N-2] = s[7:0];
        rom[N-1] = s[15:8];
    endtask

    task automatic run_one(input int kind, input logic rp, input logic cp,
                           input int exp_code, input bit restart);
        int s0, z0, rs0, cs0;
        bit rom_ok;
        fill_rom(kind);
        cfg_ram_pass = rp;
        cfg_chan_pass = cp;
        s0 = strobes; z0 = zero_bits; rs0 = ram_starts; cs0 = chan_starts;
        order_err = 0;
        if (restart) begin
            test_mode_i = 1'b1;
            while (result_valid_o) @(negedge clk);
            test_mode_i = 1'b0;
            check("R9 restart valid", result_valid_o, 0);
            check("R9 restart code cleared", result_code_o, 0);
        end
        while (!result_valid_o) @(negedge clk);
        rom_ok = (kind != 1) && (kind != 2);
        check("R2 lamp strobes", strobes - s0, 2 * PB);
        check("R2 lamp ones", zero_bits - z0, 0);
        check("R3 hold lower", (gap >= HOLD) ? 1 : 0, 1);
        check("R3 hold upper", (gap <= HOLD + 6) ? 1 : 0, 1);
        check("R4 read count", reads, N);
        check("R4 read order", order_err, 0);
        check("R5 R6 R7 result code", result_code_o, exp_code);
        check("R5 R6 ram start count", ram_starts - rs0, rom_ok ? 1 : 0);
        check("R6 R7 chan start count", chan_starts - cs0, (rom_ok && rp) ? 1 : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks = n_checks + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int s_idle, r_idle, c_idle;
        fill_rom(0);
        repeat (4) @(negedge clk);
        check("R1 reset valid", result_valid_o, 0);
        check("R1 reset code", result_code_o, 0);
        check("R1 reset quiet", disp_shift_o | rom_rd_o | ram_start_o | chan_start_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 running valid low", result_valid_o, 0);
        // R1 first run needs no input; good ROM, all pass
        run_one(0, 1'b1, 1'b1, 1, 1'b0);
        run_one(1, 1'b1, 1'b1, 2, 1'b1);   // R5 off by one
        run_one(2, 1'b1, 1'b1, 2, 1'b1);   // R5 byte order
        run_one(3, 1'b1, 1'b1, 1, 1'b1);   // R5 wrapped sum
        run_one(4, 1'b1, 1'b1, 1, 1'b1);   // R5 zero image
        run_one(0, 1'b0, 1'b1, 2, 1'b1);   // R6 ram fail
        run_one(0, 1'b1, 1'b0, 3, 1'b1);   // R7 channel fail
        run_one(3, 1'b0, 1'b0, 2, 1'b1);   // R6 ram fail masks channel
        // R8 idle hold without test mode
        s_idle = strobes; r_idle = ram_starts; c_idle = chan_starts;
        repeat (200) @(negedge clk);
        check("R8 held valid", result_valid_o, 1);
        check("R8 held code", result_code_o, 2);
        check("R8 no lamp activity", strobes - s_idle, 0);
        check("R8 no tester activity", (ram_starts - r_idle) + (chan_starts - c_idle), 0);
        check("R10 quiet after done", disp_shift_o | rom_rd_o, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule